// File: doc/BRIEF.md
# Machine Timer Comparator

This block keeps a free-running 64-bit time counter and a 64-bit compare value for one processor core. Both are reached over a 32-bit register port as a low word and a high word. The counter advances by one on each cycle in which a tick enable is high. The tick enable is produced elsewhere from whatever time base the chip uses.

The block registers the unsigned result of "time is at or past compare" as a level pending flag. It also presents an interrupt request, which is that flag gated by a global machine interrupt enable and by a timer-specific enable. When the request is high, the block drives the cause code of the timer interrupt beside it. Trap entry belongs to the core that consumes these outputs.

Top module: `mtimer_cmp`

## Requirements
- R1: While reset is asserted and after it is released, time reads as zero, compare reads as all ones, and pending, request and cause are all zero.
- R2: Word index 0 selects the low 32 bits of time, index 1 the high 32 bits of time, index 2 the low 32 bits of compare and index 3 the high 32 bits of compare. A read returns the selected word combinationally, in the same cycle.
- R3: A write stores the data word into the addressed half at the clock edge. The other half of the same register is left unchanged.
- R4: With tick enable high and no write to time, time grows by exactly one per clock edge. The carry passes from the low word into the high word, and the counter wraps from 2^64-1 to zero.
- R5: A write to either half of time in a cycle with tick enable high stores the written word and suppresses the increment for that edge, so the other half keeps its value.
- R6: With tick enable low and no write to time, time keeps its value. Without a write to compare, compare keeps its value.
- R7: The pending output is the unsigned comparison time >= compare, registered. It reflects the register values one clock edge after they change.
- R8: Writing compare to a value above time clears pending on the second clock edge counted from the write edge. Pending still reads high in the cycle right after the write.
- R9: The interrupt request equals pending AND the global enable AND the timer enable, combinationally, in the same cycle.
- R10: The cause output is 7 while the request is high and 0 while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Advance time by one at this edge |
| bus_we | input | 1 | Write strobe for the register port |
| bus_idx | input | 2 | Word index (0/1 time low/high, 2/3 compare low/high) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at bus_idx |
| glb_int_en | input | 1 | Global machine interrupt enable |
| tmr_int_en | input | 1 | Timer interrupt enable |
| tmr_pending | output | 1 | Registered time >= compare flag |
| irq_req | output | 1 | Gated timer interrupt request |
| irq_cause | output | 4 | Cause code, 7 while irq_req is high |

## Verification
Read data, the request and the cause are combinational, so they are due in the same cycle as their inputs. A register write is visible on reads after the write edge. Pending lags the registers by one further edge.

The bench drives inputs at the falling edge and samples one falling edge after a write. It checks pending a second falling edge later, and it checks the one-cycle-stale value on purpose right after a compare write. Ticks are counted in whole edges between falling edges, so the expected time is the start value plus the tick count, computed in 64-bit arithmetic. Comparison sweeps place compare at offsets -3..+3 around three bases, including the 32-bit carry boundary and the top of the range.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  // interrupt cause reported for the machine timer
  localparam int unsigned TMR_CAUSE_CODE = 7;
  // reset value of the compare register (all ones keeps pending low)
  localparam bit CMP_RST_ONES = 1'b1;
endpackage

// File: rtl/mtimer_word_reg.sv
module mtimer_word_reg #(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned HALVES = 2,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned BASE   = 0,
  parameter bit          COUNTS = 1'b0,
  parameter bit          RST_ONES = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cnt_en,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [BUS_W-1:0]          wr_data,
  output logic [BUS_W*HALVES-1:0]   value
);
  localparam int unsigned VAL_W = BUS_W * HALVES;

  logic [VAL_W-1:0]  val_q;
  logic [VAL_W-1:0]  val_d;
  logic [VAL_W-1:0]  stepped;
  logic [HALVES-1:0] hit;
  logic              any_hit;
  logic              step;
  logic              upd;

  genvar g;
  generate
    for (g = 0; g < HALVES; g++) begin : g_hit
      assign hit[g] = wr_en && (wr_idx == IDX_W'(BASE + g));
    end
    if (COUNTS) begin : g_cnt
      assign step = cnt_en & ~any_hit;
    end else begin : g_nocnt
      assign step = cnt_en & 1'b0;
    end
  endgenerate

  assign any_hit = |hit;
  assign upd     = step | any_hit;

  // next-state
  always_comb begin
    stepped = step ? (val_q + VAL_W'(1)) : val_q;
    for (int h = 0; h < HALVES; h++) begin
      val_d[h*BUS_W +: BUS_W] = hit[h] ? wr_data : stepped[h*BUS_W +: BUS_W];
    end
  end

  // state register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= RST_ONES ? {VAL_W{1'b1}} : {VAL_W{1'b0}};
    end else if (upd) begin
      val_q <= val_d;
    end
  end

  assign value = val_q;

  generate
    for (g = 0; g < HALVES; g++) begin : g_chk
      // R3 / R5: a written half takes the bus word
      a_r3_half_written: assert property (@(posedge clk) disable iff (!rst_n)
        hit[g] |=> value[g*BUS_W +: BUS_W] == $past(wr_data));
      // R3 / R5: the half not addressed is left alone
      a_r5_other_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (any_hit && !hit[g]) |=> $stable(value[g*BUS_W +: BUS_W]));
    end
    if (COUNTS) begin : g_cnt_chk
      a_r4_tick_increments: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !any_hit) |=> value == $past(value) + VAL_W'(1));
    end
  endgenerate

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_hit && !(cnt_en && COUNTS)) |=> $stable(value));

endmodule

// File: rtl/mtimer_pend.sv
module mtimer_pend #(
  parameter int unsigned VAL_W   = 64,
  parameter int unsigned CAUSE_W = 4,
  parameter int unsigned CAUSE   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VAL_W-1:0]   time_val,
  input  logic [VAL_W-1:0]   cmp_val,
  input  logic               glb_ie,
  input  logic               src_ie,
  output logic               pending,
  output logic               req,
  output logic [CAUSE_W-1:0] cause
);
  logic pend_q;
  logic pend_d;

  // next-state: unsigned level comparison
  always_comb begin
    pend_d = (time_val >= cmp_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;
  assign req     = pend_q & glb_ie & src_ie;
  assign cause   = req ? CAUSE_W'(CAUSE) : '0;

  // R7: pending follows the comparison of the previous cycle
  a_r7_pending_lags: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pending == $past(time_val >= cmp_val));
  // R9: a new request needs a rising term among its three inputs
  a_r9_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> ($rose(pending) || $rose(glb_ie) || $rose(src_ie)));
  // R10: cause code accompanies the request
  a_r10_cause_code: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> cause == CAUSE_W'(CAUSE));
  a_r10_cause_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> cause == '0);

endmodule

// File: rtl/mtimer_cmp.sv
module mtimer_cmp #(
  parameter int unsigned BUS_W   = 32,
  parameter int unsigned HALVES  = 2,
  parameter int unsigned CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               bus_we,
  input  logic [1:0]         bus_idx,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic               glb_int_en,
  input  logic               tmr_int_en,
  output logic               tmr_pending,
  output logic               irq_req,
  output logic [CAUSE_W-1:0] irq_cause
);
  import mtimer_pkg::*;

  localparam int unsigned VAL_W  = BUS_W * HALVES;
  localparam int unsigned NWORDS = 2 * HALVES;
  localparam int unsigned IDX_W  = 2;

  logic [VAL_W-1:0]        time_val;
  logic [VAL_W-1:0]        cmp_val;
  logic [NWORDS*BUS_W-1:0] word_flat;

  mtimer_word_reg #(
    .BUS_W(BUS_W), .HALVES(HALVES), .IDX_W(IDX_W),
    .BASE(0), .COUNTS(1'b1), .RST_ONES(1'b0)
  ) u_time (
    .clk(clk), .rst_n(rst_n), .cnt_en(tick_en),
    .wr_en(bus_we), .wr_idx(bus_idx), .wr_data(bus_wdata),
    .value(time_val)
  );

  mtimer_word_reg #(
    .BUS_W(BUS_W), .HALVES(HALVES), .IDX_W(IDX_W),
    .BASE(HALVES), .COUNTS(1'b0), .RST_ONES(CMP_RST_ONES)
  ) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt_en(1'b0),
    .wr_en(bus_we), .wr_idx(bus_idx), .wr_data(bus_wdata),
    .value(cmp_val)
  );

  mtimer_pend #(
    .VAL_W(VAL_W), .CAUSE_W(CAUSE_W), .CAUSE(TMR_CAUSE_CODE)
  ) u_pend (
    .clk(clk), .rst_n(rst_n),
    .time_val(time_val), .cmp_val(cmp_val),
    .glb_ie(glb_int_en), .src_ie(tmr_int_en),
    .pending(tmr_pending), .req(irq_req), .cause(irq_cause)
  );

  // read mux: words laid out time first, then compare
  assign word_flat = {cmp_val, time_val};
  always_comb begin
    bus_rdata = word_flat[bus_idx*BUS_W +: BUS_W];
  end

  // R1: reset leaves no request
  a_r1_no_req_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !irq_req);
  // R8: raising compare above time drops pending two edges later
  a_r8_cmp_raise_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && !tick_en && (cmp_val > time_val)) |=> !tmr_pending);

endmodule

// File: tb/sim_mtimer_cmp.sv
module sim_mtimer_cmp;
  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        bus_we;
  logic [1:0]  bus_idx;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        glb_int_en;
  logic        tmr_int_en;
  logic        tmr_pending;
  logic        irq_req;
  logic [3:0]  irq_cause;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  mtimer_cmp u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_we(bus_we), .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .glb_int_en(glb_int_en), .tmr_int_en(tmr_int_en),
    .tmr_pending(tmr_pending), .irq_req(irq_req), .irq_cause(irq_cause)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [1:0] idx, input logic [31:0] data);
    @(negedge clk);
    bus_we = 1'b1; bus_idx = idx; bus_wdata = data;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd64(input logic [1:0] idx, output logic [63:0] v);
    logic [31:0] lo;
    bus_idx = idx;       #1; lo = bus_rdata;
    bus_idx = idx + 2'd1; #1; v = {bus_rdata, lo};
  endtask

  task automatic set64(input logic [1:0] idx, input logic [63:0] v);
    wr_word(idx, v[31:0]);
    wr_word(idx + 2'd1, v[63:32]);
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [63:0] b;
    logic [63:0] c;
    rst_n = 1'b0; tick_en = 1'b0; bus_we = 1'b0; bus_idx = '0; bus_wdata = '0;
    glb_int_en = 1'b1; tmr_int_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd64(2'd0, v); chk("R1 time", v, 64'd0);
    rd64(2'd2, v); chk("R1 cmp", v, {64{1'b1}});
    chk("R1 pending", {63'd0, tmr_pending}, 64'd0);
    chk("R1 irq", {63'd0, irq_req}, 64'd0);
    chk("R1 cause", {60'd0, irq_cause}, 64'd0);

    // R2 / R3 word map and half writes
    wr_word(2'd0, 32'h0000_0010);
    rd64(2'd0, v); chk("R2 time lo write", v, 64'h0000_0000_0000_0010);
    wr_word(2'd1, 32'h0000_000A);
    rd64(2'd0, v); chk("R3 time hi keeps lo", v, 64'h0000_000A_0000_0010);
    wr_word(2'd2, 32'h1234_5678);
    rd64(2'd2, v); chk("R3 cmp lo keeps hi", v, 64'hFFFF_FFFF_1234_5678);
    wr_word(2'd3, 32'h0000_0003);
    rd64(2'd2, v); chk("R2 cmp hi", v, 64'h0000_0003_1234_5678);
    rd64(2'd0, v); chk("R6 cmp write leaves time", v, 64'h0000_000A_0000_0010);

    // R4 increment, carry and wrap
    set64(2'd0, 64'd1000);
    ticks(5);
    rd64(2'd0, v); chk("R4 five ticks", v, 64'd1005);
    set64(2'd0, 64'h0000_0005_FFFF_FFFF);
    ticks(1);
    rd64(2'd0, v); chk("R4 carry into hi", v, 64'h0000_0006_0000_0000);
    set64(2'd0, 64'hFFFF_FFFF_FFFF_FFFE);
    ticks(3);
    rd64(2'd0, v); chk("R4 wrap to zero", v, 64'd1);

    // R6 idle hold
    set64(2'd0, 64'd777);
    repeat (4) @(negedge clk);
    rd64(2'd0, v); chk("R6 idle hold", v, 64'd777);

    // R5 write wins over tick, other half kept
    set64(2'd0, 64'h0000_0002_FFFF_FFFF);
    @(negedge clk);
    tick_en = 1'b1; bus_we = 1'b1; bus_idx = 2'd1; bus_wdata = 32'h0000_0009;
    @(negedge clk);
    tick_en = 1'b0; bus_we = 1'b0;
    rd64(2'd0, v); chk("R5 write beats tick", v, 64'h0000_0009_FFFF_FFFF);

    // R7 comparison sweep around three bases
    for (int i = 0; i < 3; i++) begin
      b = (i == 0) ? 64'd5 : (i == 1) ? 64'h0000_0001_0000_0000 : 64'hFFFF_FFFF_FFFF_FFF0;
      for (int d = -3; d <= 3; d++) begin
        c = b + 64'(signed'(d));
        set64(2'd0, b);
        set64(2'd2, c);
        @(negedge clk);
        chk($sformatf("R7 base%0d off%0d", i, d), {63'd0, tmr_pending}, {63'd0, (b >= c)});
      end
    end

    // R8 raising compare clears pending, one cycle late
    set64(2'd0, 64'd100);
    set64(2'd2, 64'd50);
    @(negedge clk);
    chk("R8 pending set first", {63'd0, tmr_pending}, 64'd1);
    wr_word(2'd2, 32'd200);
    chk("R8 still set right after write", {63'd0, tmr_pending}, 64'd1);
    @(negedge clk);
    chk("R8 cleared", {63'd0, tmr_pending}, 64'd0);

    // R9 / R10 enable gating and cause
    for (int p = 0; p < 2; p++) begin
      set64(2'd2, (p == 1) ? 64'd50 : 64'd200);
      @(negedge clk);
      for (int e = 0; e < 4; e++) begin
        glb_int_en = e[0]; tmr_int_en = e[1];
        #1;
        chk($sformatf("R9 p%0d e%0d", p, e), {63'd0, irq_req},
            {63'd0, (p == 1) && e[0] && e[1]});
        chk($sformatf("R10 p%0d e%0d", p, e), {60'd0, irq_cause},
            ((p == 1) && e[0] && e[1]) ? 64'd7 : 64'd0);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule